// File: doc/BRIEF.md
# Serial NOR Flash Fast-Read Controller

This block is an SPI master that reads bytes from a serial NOR flash. After reset it sends the wake-from-deep-power-down opcode on a chip-select cycle of its own. It then keeps chip select high for a programmable number of system clocks so that the device has time to wake. Only after that wait does it raise `boot_done` and start to accept read requests.

A read request gives a 24-bit start address and a byte count through a valid/ready handshake. The controller checks that the range fits within the device size. It then sends the fast-read opcode, the address and eight dummy clocks, and returns each received byte on `rd_data` with a one-cycle `rd_valid` strobe. The downstream consumer can pause the data phase by lowering `rd_ready`, which freezes SCK. A request that starts past the device end, runs past it, or has a zero length is refused with a one-cycle `req_err` pulse. No bus activity follows a refused request.

The SCK period is `CLK_DIV` system clocks, where `CLK_DIV` is even and at least 2. `WAKE_CYCLES` is the number of system clocks that make up the wake-up time; at 200 MHz, 600 clocks give 3000 ns.

Top module: `spi_flash_reader`

## Requirements
- R1: While `rst_n` is low and on the cycle after it, `cs_n` is 1, `sck` is 0, `boot_done` is 0 and `req_ready` is 0.
- R2: The first transaction after reset is exactly 8 SCK clocks carrying opcode 0xAB, MSB first, on a chip-select cycle of its own.
- R3: After that transaction `cs_n` stays high for at least `WAKE_CYCLES` clocks, and `boot_done` rises only once that interval has passed.
- R4: A read transaction sends opcode 0x0B, then the 24-bit start address MSB first, then 8 dummy clocks with MOSI low, and then the data clocks.
- R5: SPI mode 0. SCK idles low whenever `cs_n` is high. MOSI changes only while SCK is low. MISO is sampled on the rising SCK edge.
- R6: Each data byte is assembled MSB first from MISO and shown on `rd_data` with a one-cycle `rd_valid`. Exactly `req_len` bytes are returned, from consecutive addresses.
- R7: `cs_n` rises after the last requested byte, once SCK is low again, so that a read of N bytes spans exactly 40 + 8·N SCK clocks.
- R8: A request with `req_len` = 0 or `req_addr + req_len > 0x200000` gives a one-cycle `req_err` pulse and leaves `cs_n` high, so that no transaction takes place.
- R9: During the data phase, SCK holds its level in every cycle in which `rd_ready` is low.
- R10: Between any two transactions, `cs_n` stays high for at least `CLK_DIV` system clocks (one SCK period).
- R11: `req_ready` is high only when the controller is idle after wake-up. A request is taken on a clock edge where `req_valid` and `req_ready` are both high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid | input | 1 | Read request present |
| req_ready | output | 1 | Controller idle and able to take a request |
| req_addr | input | 24 | Start byte address |
| req_len | input | LEN_W | Number of bytes to read |
| req_err | output | 1 | One-cycle pulse: request refused |
| boot_done | output | 1 | Wake-up sequence and wait complete |
| rd_data | output | 8 | Received byte |
| rd_valid | output | 1 | One-cycle strobe for `rd_data` |
| rd_ready | input | 1 | Consumer ready; low freezes SCK in the data phase |
| sck | output | 1 | SPI clock |
| cs_n | output | 1 | Flash chip select, active low |
| mosi | output | 1 | Serial data to flash |
| miso | input | 1 | Serial data from flash |

## Verification
The bench attaches a behavioural flash whose byte at each address is a function of that address. It sends reads from a table, and each row is chosen to separate one failure mode from the others. An aligned start, an unaligned start and a read that crosses a low-byte carry show whether the address is sent correctly and whether consecutive bytes follow it. Ranges that end exactly at the device size, run one byte past it, or start beyond it show whether the bound is inclusive or exclusive. A zero-length request covers the empty case. One row toggles `rd_ready` during the data phase, which shows whether SCK is frozen rather than bytes being dropped or duplicated. A reset in the middle of a read confirms that the wake opcode and the wait come first again.

// File: rtl/spi_flash_reader.sv
`timescale 1ns/1ps
module spi_flash_reader #(
  parameter int CLK_DIV     = 4,
  parameter int WAKE_CYCLES = 600,
  parameter int LEN_W       = 12,
  parameter int MEM_BYTES   = 2097152
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [23:0]      req_addr,
  input  logic [LEN_W-1:0] req_len,
  output logic             req_err,
  output logic             boot_done,
  output logic [7:0]       rd_data,
  output logic             rd_valid,
  input  logic             rd_ready,
  output logic             sck,
  output logic             cs_n,
  output logic             mosi,
  input  logic             miso
);
  localparam int HALF = CLK_DIV / 2;
  localparam int DW   = $clog2(HALF) + 1;
  localparam int WMAX = (WAKE_CYCLES > CLK_DIV) ? WAKE_CYCLES : CLK_DIV;
  localparam int WW   = $clog2(WMAX) + 1;
  localparam int SW   = 40;

  typedef enum logic [2:0] {S_BOOT, S_WAKE, S_WWAIT, S_IDLE, S_CMD, S_DATA, S_GAP} st_t;

  st_t             st;
  logic [DW-1:0]   div;
  logic [WW-1:0]   wcnt;
  logic [SW-1:0]   sh;
  logic [5:0]      bits;
  logic [LEN_W-1:0] left;
  logic [7:0]      rx;
  logic            in_data, shifting, tick, bad;

  assign req_ready = (st == S_IDLE);
  assign boot_done = (st == S_IDLE) || (st == S_CMD) || (st == S_DATA) || (st == S_GAP);
  assign in_data   = (st == S_DATA);
  assign shifting  = (st == S_WAKE) || (st == S_CMD) || (in_data && rd_ready);
  assign tick      = shifting && (div == DW'(HALF - 1));
  assign mosi      = sh[SW-1];
  assign bad       = (req_len == '0) ||
                     (({1'b0, req_addr} + 25'(req_len)) > 25'(MEM_BYTES));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_BOOT;  cs_n <= 1'b1;  sck <= 1'b0;  div <= '0;  wcnt <= '0;
      sh <= '0;  bits <= '0;  left <= '0;  rx <= '0;
      rd_data <= '0;  rd_valid <= 1'b0;  req_err <= 1'b0;
    end else begin
      rd_valid <= 1'b0;
      req_err  <= 1'b0;
      if (shifting) div <= tick ? '0 : div + DW'(1);
      case (st)
        S_BOOT: begin
          sh <= {8'hAB, 32'h0};
          bits <= 6'd8;
          cs_n <= 1'b0;
          div <= '0;
          st <= S_WAKE;
        end
        S_WWAIT:
          if (wcnt == WW'(WAKE_CYCLES - 1)) st <= S_IDLE;
          else wcnt <= wcnt + WW'(1);
        S_GAP:
          if (wcnt == WW'(CLK_DIV - 1)) st <= S_IDLE;
          else wcnt <= wcnt + WW'(1);
        S_IDLE:
          if (req_valid) begin
            if (bad) req_err <= 1'b1;
            else begin
              sh <= {8'h0B, req_addr, 8'h00};
              bits <= 6'd40;
              left <= req_len;
              cs_n <= 1'b0;
              div <= '0;
              st <= S_CMD;
            end
          end
        default:
          if (tick) begin
            if (!sck) begin
              sck  <= 1'b1;
              bits <= bits - 6'd1;
              rx   <= {rx[6:0], miso};
              if (in_data && bits == 6'd1) begin
                rd_valid <= 1'b1;
                rd_data  <= {rx[6:0], miso};
                left     <= left - LEN_W'(1);
              end
            end else begin
              sck <= 1'b0;
              if (bits != 6'd0) sh <= {sh[SW-2:0], 1'b0};
              else if (st == S_WAKE) begin
                cs_n <= 1'b1;  wcnt <= '0;  st <= S_WWAIT;
              end else if (st == S_CMD) begin
                bits <= 6'd8;  st <= S_DATA;
              end else if (left != '0) bits <= 6'd8;
              else begin
                cs_n <= 1'b1;  wcnt <= '0;  st <= S_GAP;
              end
            end
          end
      endcase
    end
  end
endmodule

module spi_flash_reader_chk #(
  parameter int CLK_DIV     = 4,
  parameter int WAKE_CYCLES = 600
) (
  input logic clk,
  input logic rst_n,
  input logic cs_n,
  input logic sck,
  input logic mosi,
  input logic boot_done,
  input logic req_ready,
  input logic req_err,
  input logic rd_valid,
  input logic rd_ready,
  input logic in_data
);
  localparam int HW = $clog2(WAKE_CYCLES + CLK_DIV + 2) + 1;
  localparam logic [HW-1:0] HMAX = '1;
  logic [HW-1:0] hi_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) hi_cnt <= '0;
    else if (!cs_n) hi_cnt <= '0;
    else if (hi_cnt != HMAX) hi_cnt <= hi_cnt + HW'(1);
  end

  p_reset_state_r1: assert property (@(posedge clk)
    !rst_n |=> (cs_n && !sck && !boot_done && !req_ready));
  p_wake_wait_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(boot_done) |-> (hi_cnt >= HW'(WAKE_CYCLES)));
  p_mosi_stable_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n && sck && $past(sck) && !$past(cs_n)) |-> $stable(mosi));
  p_sck_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> !sck);
  p_valid_in_txn_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> !cs_n);
  p_err_no_txn_r8: assert property (@(posedge clk) disable iff (!rst_n)
    req_err |-> (cs_n && req_ready));
  p_stall_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (in_data && !rd_ready) |=> $stable(sck));
  p_cs_gap_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(cs_n) && boot_done) |-> (hi_cnt >= HW'(CLK_DIV)));
  p_hold_off_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !boot_done |-> !req_ready);
endmodule

bind spi_flash_reader spi_flash_reader_chk #(.CLK_DIV(CLK_DIV), .WAKE_CYCLES(WAKE_CYCLES)) u_chk (
  .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .mosi(mosi),
  .boot_done(boot_done), .req_ready(req_ready), .req_err(req_err),
  .rd_valid(rd_valid), .rd_ready(rd_ready), .in_data(in_data)
);

// File: tb/sim_spi_flash_reader.sv
`timescale 1ns/1ps
module sim_spi_flash_reader;
  localparam int CLK_DIV = 4;
  localparam int WAKE    = 600;

  logic clk = 0, rst_n = 0, req_valid = 0, host_rdy = 1, miso = 0;
  logic [23:0] req_addr = 0;
  logic [11:0] req_len = 0;
  logic req_ready, req_err, boot_done, rd_valid, sck, cs_n, mosi;
  logic [7:0] rd_data;

  spi_flash_reader #(.CLK_DIV(CLK_DIV), .WAKE_CYCLES(WAKE), .LEN_W(12)) u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_len(req_len), .req_err(req_err), .boot_done(boot_done),
    .rd_data(rd_data), .rd_valid(rd_valid), .rd_ready(host_rdy),
    .sck(sck), .cs_n(cs_n), .mosi(mosi), .miso(miso));

  always #2.5 clk = ~clk;

  int checks = 0, errors = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] fbyte(input logic [23:0] a);
    return a[7:0] ^ a[15:8] ^ {3'b0, a[20:16]} ^ 8'hC3;
  endfunction

  // behavioural flash
  int bitn = 0, txn_cnt = 0, last_bits = 0;
  logic [39:0] fsh = 0, last_sh = 0;
  time t_rise = 0, wake_gap = 0, min_gap = 64'd1000000;
  bit gap_track = 0;

  always @(negedge cs_n) begin
    if (gap_track && last_bits != 8 && ($time - t_rise) < min_gap) min_gap = $time - t_rise;
    if (last_bits == 8 && last_sh[7:0] == 8'hAB) wake_gap = $time - t_rise;
    bitn = 0;
    fsh = 0;
  end
  always @(posedge cs_n) begin
    if (bitn != 0) begin
      txn_cnt++;
      last_bits = bitn;
      last_sh = fsh;
      t_rise = $time;
    end
  end
  always @(posedge sck) if (!cs_n) begin
    if (bitn < 40) fsh = {fsh[38:0], mosi};
    bitn++;
  end
  always @(negedge sck) if (!cs_n && bitn >= 40) begin
    int idx;
    logic [7:0] b;
    idx = bitn - 40;
    b = fbyte(fsh[31:8] + 24'(idx / 8));
    miso = b[7 - (idx % 8)];
  end

  // data collector and error counter
  logic [7:0] rx_buf [0:15];
  int rx_n = 0, err_cnt = 0;
  always @(negedge clk) begin
    if (rd_valid) begin
      if (rx_n < 16) rx_buf[rx_n] = rd_data;
      rx_n++;
    end
    if (req_err) err_cnt++;
  end

  // consumer ready pattern, updated just after each rising edge
  bit stall_en = 0;
  int cyc_h = 0;
  initial forever begin
    @(posedge clk);
    #1;
    cyc_h++;
    host_rdy = !stall_en || ((cyc_h % 5) >= 2);
  end

  // R9: SCK frozen while the consumer is not ready in the data phase
  bit stall_armed = 0;
  logic stall_sck = 0;
  int stall_n = 0;
  always @(negedge clk) begin
    if (stall_armed) begin
      stall_n++;
      chk(sck == stall_sck, "R9 sck held during stall", sck, stall_sck);
    end
    stall_armed = rst_n && !host_rdy && !cs_n && bitn >= 40 && !sck;
    stall_sck = sck;
  end

  task automatic do_req(input logic [23:0] a, input logic [11:0] n, input bit st);
    bit exp_err;
    int e0, t0;
    exp_err = (n == 0) || (({1'b0, a} + {13'b0, n}) > 25'h200000);
    while (!req_ready) @(negedge clk);
    rx_n = 0; e0 = err_cnt; t0 = txn_cnt; stall_en = st;
    req_valid = 1; req_addr = a; req_len = n;
    @(negedge clk);
    req_valid = 0;
    while (!req_ready) @(negedge clk);
    repeat (2) @(negedge clk);
    stall_en = 0;
    chk((err_cnt - e0) == (exp_err ? 1 : 0), "R8 error pulse count", err_cnt - e0, exp_err);
    if (exp_err) begin
      chk(txn_cnt == t0, "R8 no transaction on refusal", txn_cnt, t0);
      chk(rx_n == 0, "R8 no data on refusal", rx_n, 0);
    end else begin
      chk(txn_cnt == t0 + 1, "R7 one transaction", txn_cnt, t0 + 1);
      chk(last_bits == 40 + 8 * n, "R7 sck clocks per read", last_bits, 40 + 8 * n);
      chk(last_sh[39:32] == 8'h0B, "R4 opcode", last_sh[39:32], 8'h0B);
      chk(last_sh[31:8] == a, "R4 address", last_sh[31:8], a);
      chk(last_sh[7:0] == 8'h00, "R4 dummy bits low", last_sh[7:0], 0);
      chk(rx_n == n, "R6 byte count", rx_n, n);
      for (int i = 0; i < n && i < 16; i++)
        chk(rx_buf[i] == fbyte(a + 24'(i)), "R6 data byte", rx_buf[i], fbyte(a + 24'(i)));
    end
  endtask

  // {stall, len, addr}
  localparam logic [36:0] VEC [0:8] = '{
    {1'b0, 12'd4, 24'h000000},
    {1'b0, 12'd3, 24'h012345},
    {1'b0, 12'd4, 24'h1FFFFC},
    {1'b0, 12'd4, 24'h1FFFFD},
    {1'b1, 12'd6, 24'h00ABCD},
    {1'b0, 12'd0, 24'h000100},
    {1'b0, 12'd2, 24'h0000FF},
    {1'b0, 12'd1, 24'h1FFFFF},
    {1'b0, 12'd1, 24'hFFFFF0}
  };

  initial begin
    time t_boot;
    repeat (3) @(negedge clk);
    chk(cs_n == 1, "R1 cs_n in reset", cs_n, 1);
    chk(sck == 0, "R1 sck in reset", sck, 0);
    chk(boot_done == 0, "R1 boot_done in reset", boot_done, 0);
    chk(req_ready == 0, "R1 req_ready in reset", req_ready, 0);
    rst_n = 1;
    repeat (100) @(negedge clk);
    chk(req_ready == 0, "R11 no request taken before wake", req_ready, 0);
    chk(boot_done == 0, "R3 boot_done low during wait", boot_done, 0);
    @(posedge boot_done);
    t_boot = $time;
    @(negedge clk);
    chk(txn_cnt == 1, "R2 single wake transaction", txn_cnt, 1);
    chk(last_bits == 8, "R2 wake clocks", last_bits, 8);
    chk(last_sh[7:0] == 8'hAB, "R2 wake opcode", last_sh[7:0], 8'hAB);
    chk((t_boot - t_rise) >= 3000, "R3 wake wait ns", t_boot - t_rise, 3000);
    gap_track = 1;
    for (int v = 0; v < 9; v++)
      do_req(VEC[v][23:0], VEC[v][35:24], VEC[v][36]);
    chk(wake_gap >= 3000, "R3 cs high after wake ns", wake_gap, 3000);
    chk(min_gap >= CLK_DIV * 5, "R10 cs high between reads ns", min_gap, CLK_DIV * 5);
    chk(stall_n > 0, "R9 stall cycles observed", stall_n, 1);
    gap_track = 0;

    // reset in the middle of a read
    while (!req_ready) @(negedge clk);
    rx_n = 0;
    req_valid = 1; req_addr = 24'h000400; req_len = 12'd8;
    @(negedge clk);
    req_valid = 0;
    while (rx_n < 2) @(negedge clk);
    rst_n = 0;
    repeat (2) @(negedge clk);
    txn_cnt = 0;
    chk(cs_n == 1, "R1 cs_n after mid-read reset", cs_n, 1);
    chk(boot_done == 0, "R1 boot_done after mid-read reset", boot_done, 0);
    rst_n = 1;
    @(posedge boot_done);
    @(negedge clk);
    chk(txn_cnt == 1 && last_sh[7:0] == 8'hAB, "R2 wake repeated after reset", last_sh[7:0], 8'hAB);
    do_req(24'h000400, 12'd8, 1'b0);

    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL R11 watchdog expired actual=running expected=complete");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule